// File: doc/BRIEF.md
# Dual-Frequency Quad-Phase NCO Core

A numerically controlled oscillator that runs on the master clock. A 32-bit phase accumulator advances every cycle by one of two tuning words. The output frequency is the tuning word times the clock frequency divided by 2^32. To produce a tone `f`, software programs the word `f * 2^32 / f_clk`, and keeps `f` at or below half the clock rate.

The top 12 bits of the accumulator are added to one of four 12-bit phase offsets to form the output phase word. Each offset step is 2π/4096 radians. The frequency and phase selects come from one of two places:
- External pins, which pass through a two-stage synchronizer.
- Register bits, which are already in the clock domain.

A source-select input chooses between them. Three controls change the datapath:
- **reset** forces the accumulator to zero and holds it there.
- **sleep** freezes the accumulator.
- **clear** zeroes the output word while the accumulator keeps running.

The output is marked enabled only while all three are low.

Top module: `nco_core`

## Requirements
- R1: Each clock edge with reset and sleep low, the accumulator adds the selected tuning word, wrapping modulo 2^32 with no saturation.
- R2: A frequency select of 0 picks `ftw0_i` and a select of 1 picks `ftw1_i`.
- R3: One edge after the accumulator holds value A, `phase_o` equals (A[31:20] + offset[psel]) mod 4096. Phase select value n (0..3) picks `phsn_i`.
- R4: With `src_pin_i` = 1 the selects come from `fsel_pin_i`/`psel_pin_i`. A pin value sampled at edge k is first used at edge k+2.
- R5: With `src_pin_i` = 0 the selects come from `fsel_reg_i`/`psel_reg_i` and are used at the very next edge.
- R6: `reset_i` high at an edge loads zero into the accumulator. It takes priority over sleep.
- R7: `sleep_i` high (reset low) at an edge leaves the accumulator unchanged.
- R8: `clear_i` high at an edge makes `phase_o` zero after that edge, while the accumulator keeps advancing.
- R9: `out_en_o` is 1 after an edge only if sleep, reset and clear were all 0 at that edge, and 0 otherwise.
- R10: While `rst_ni` is low, `acc_o`, `phase_o` and `out_en_o` are zero and the synchronizer stages are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ftw0_i | input | 32 | Tuning word 0 |
| ftw1_i | input | 32 | Tuning word 1 |
| phs0_i | input | 12 | Phase offset 0 |
| phs1_i | input | 12 | Phase offset 1 |
| phs2_i | input | 12 | Phase offset 2 |
| phs3_i | input | 12 | Phase offset 3 |
| src_pin_i | input | 1 | 1: selects from pins, 0: from register bits |
| fsel_pin_i | input | 1 | Frequency select pin (asynchronous) |
| psel_pin_i | input | 2 | Phase select pins (asynchronous) |
| fsel_reg_i | input | 1 | Frequency select register bit |
| psel_reg_i | input | 2 | Phase select register bits |
| sleep_i | input | 1 | Freeze accumulator |
| reset_i | input | 1 | Hold accumulator at zero |
| clear_i | input | 1 | Zero the output phase word |
| acc_o | output | 32 | Accumulator value |
| phase_o | output | 12 | Output phase word |
| out_en_o | output | 1 | Output valid/enabled |

## Verification
The assertions assume that sleep, reset and clear are synchronous to the master clock and stable around each edge. Only the select pins may be asynchronous.

The bench drives every input on the falling edge, so the pin inputs never change near a rising edge. The two-stage latency can therefore be predicted exactly.

The reference model tracks this latency with its own two-deep history of pin values. It applies the control priority reset > sleep > run that the requirements state.

// File: rtl/nco_pkg.sv
`timescale 1ns/1ps
package nco_pkg;
  localparam int unsigned N_FTW      = 2;
  localparam int unsigned N_PHS      = 4;
  localparam int unsigned FSEL_W     = $clog2(N_FTW);
  localparam int unsigned PSEL_W     = $clog2(N_PHS);
  localparam int unsigned SYNC_DEPTH = 2;

  typedef struct packed {
    logic sleep;
    logic hold_rst;
    logic clr;
  } nco_ctrl_t;
endpackage

// File: rtl/nco_sync.sv
`timescale 1ns/1ps
module nco_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/nco_sel_src.sv
`timescale 1ns/1ps
module nco_sel_src #(
  parameter int unsigned FSEL_W     = 1,
  parameter int unsigned PSEL_W     = 2,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_pin_i,
  input  logic [FSEL_W-1:0] fsel_pin_i,
  input  logic [PSEL_W-1:0] psel_pin_i,
  input  logic [FSEL_W-1:0] fsel_reg_i,
  input  logic [PSEL_W-1:0] psel_reg_i,
  output logic [FSEL_W-1:0] fsel_o,
  output logic [PSEL_W-1:0] psel_o
);
  localparam int unsigned SEL_W = FSEL_W + PSEL_W;

  logic [SEL_W-1:0] pin_raw, pin_sync;

  assign pin_raw = {fsel_pin_i, psel_pin_i};

  generate
    if (SYNC_DEPTH > 0) begin : g_sync
      nco_sync #(.W(SEL_W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pin_raw),
        .q_o    (pin_sync)
      );
    end else begin : g_nosync
      assign pin_sync = pin_raw;
    end
  endgenerate

  assign fsel_o = src_pin_i ? pin_sync[SEL_W-1 -: FSEL_W] : fsel_reg_i;
  assign psel_o = src_pin_i ? pin_sync[PSEL_W-1:0]       : psel_reg_i;
endmodule

// File: rtl/nco_accum.sv
`timescale 1ns/1ps
module nco_accum
  import nco_pkg::*;
#(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned PHS_W = 12
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_FTW-1:0][ACC_W-1:0]  ftw_i,
  input  logic [N_PHS-1:0][PHS_W-1:0]  phs_i,
  input  logic [FSEL_W-1:0]            fsel_i,
  input  logic [PSEL_W-1:0]            psel_i,
  input  nco_ctrl_t                    ctrl_i,
  output logic [ACC_W-1:0]             acc_o,
  output logic [PHS_W-1:0]             phase_o,
  output logic                         out_en_o
);
  logic [ACC_W-1:0] acc_q;
  logic [PHS_W-1:0] ph_q, ph_sum;
  logic             en_q;

  // offset applies to the accumulator MSBs only
  assign ph_sum = acc_q[ACC_W-1 -: PHS_W] + phs_i[psel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ph_q  <= '0;
      en_q  <= 1'b0;
    end else begin
      if (ctrl_i.hold_rst)   acc_q <= '0;
      else if (!ctrl_i.sleep) acc_q <= acc_q + ftw_i[fsel_i];
      ph_q <= ctrl_i.clr ? '0 : ph_sum;
      en_q <= ~(ctrl_i.sleep | ctrl_i.hold_rst | ctrl_i.clr);
    end
  end

  assign acc_o    = acc_q;
  assign phase_o  = ph_q;
  assign out_en_o = en_q;

  p_reset_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.hold_rst |=> (acc_o == '0));

  p_sleep_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.sleep && !ctrl_i.hold_rst) |=> $stable(acc_o));

  p_clear_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.clr |=> (phase_o == '0));

  p_out_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.sleep || ctrl_i.hold_rst || ctrl_i.clr) |=> !out_en_o);

  p_out_on_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_i.sleep || ctrl_i.hold_rst || ctrl_i.clr) |=> out_en_o);
endmodule

// File: rtl/nco_core.sv
`timescale 1ns/1ps
module nco_core
  import nco_pkg::*;
#(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned PHS_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] ftw0_i,
  input  logic [ACC_W-1:0] ftw1_i,
  input  logic [PHS_W-1:0] phs0_i,
  input  logic [PHS_W-1:0] phs1_i,
  input  logic [PHS_W-1:0] phs2_i,
  input  logic [PHS_W-1:0] phs3_i,
  input  logic             src_pin_i,
  input  logic             fsel_pin_i,
  input  logic [1:0]       psel_pin_i,
  input  logic             fsel_reg_i,
  input  logic [1:0]       psel_reg_i,
  input  logic             sleep_i,
  input  logic             reset_i,
  input  logic             clear_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [PHS_W-1:0] phase_o,
  output logic             out_en_o
);
  logic [N_FTW-1:0][ACC_W-1:0] ftw;
  logic [N_PHS-1:0][PHS_W-1:0] phs;
  logic [FSEL_W-1:0]           fsel;
  logic [PSEL_W-1:0]           psel;
  nco_ctrl_t                   ctrl;

  assign ftw  = {ftw1_i, ftw0_i};
  assign phs  = {phs3_i, phs2_i, phs1_i, phs0_i};
  assign ctrl = '{sleep: sleep_i, hold_rst: reset_i, clr: clear_i};

  nco_sel_src #(.FSEL_W(FSEL_W), .PSEL_W(PSEL_W), .SYNC_DEPTH(SYNC_DEPTH)) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_pin_i  (src_pin_i),
    .fsel_pin_i (fsel_pin_i),
    .psel_pin_i (psel_pin_i),
    .fsel_reg_i (fsel_reg_i),
    .psel_reg_i (psel_reg_i),
    .fsel_o     (fsel),
    .psel_o     (psel)
  );

  nco_accum #(.ACC_W(ACC_W), .PHS_W(PHS_W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ftw_i    (ftw),
    .phs_i    (phs),
    .fsel_i   (fsel),
    .psel_i   (psel),
    .ctrl_i   (ctrl),
    .acc_o    (acc_o),
    .phase_o  (phase_o),
    .out_en_o (out_en_o)
  );
endmodule

// File: tb/nco_core_bench.sv
`timescale 1ns/1ps
module nco_core_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_ni;
  logic [31:0] ftw [2];
  logic [11:0] phs [4];
  logic        src_pin, fsel_pin, fsel_reg, sleep, rst_h, clear;
  logic [1:0]  psel_pin, psel_reg;
  logic [31:0] acc_o;
  logic [11:0] phase_o;
  logic        out_en_o;

  nco_core u_nco_core (
    .clk_i(clk), .rst_ni(rst_ni),
    .ftw0_i(ftw[0]), .ftw1_i(ftw[1]),
    .phs0_i(phs[0]), .phs1_i(phs[1]), .phs2_i(phs[2]), .phs3_i(phs[3]),
    .src_pin_i(src_pin), .fsel_pin_i(fsel_pin), .psel_pin_i(psel_pin),
    .fsel_reg_i(fsel_reg), .psel_reg_i(psel_reg),
    .sleep_i(sleep), .reset_i(rst_h), .clear_i(clear),
    .acc_o(acc_o), .phase_o(phase_o), .out_en_o(out_en_o)
  );

  typedef struct {
    logic [31:0] acc;
    logic [11:0] ph;
    logic        en;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [31:0] m_acc = '0;
  logic        m_f1 = 0, m_f2 = 0;
  logic [1:0]  m_p1 = 0, m_p2 = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: predict the result of the coming rising edge, then advance
  task automatic cyc(input string tag);
    exp_t        e;
    logic        fs;
    logic [1:0]  ps;
    logic [31:0] nacc;
    fs = src_pin ? m_f2 : fsel_reg;
    ps = src_pin ? m_p2 : psel_reg;
    e.ph = clear ? 12'h000 : 12'(m_acc[31:20] + phs[ps]);
    if (rst_h)      nacc = '0;
    else if (sleep) nacc = m_acc;
    else            nacc = m_acc + ftw[fs];
    e.acc = nacc;
    e.en  = !(sleep || rst_h || clear);
    e.tag = tag;
    q.push_back(e);
    m_acc = nacc;
    m_f2 = m_f1; m_f1 = fsel_pin;
    m_p2 = m_p1; m_p1 = psel_pin;
    @(negedge clk);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(acc_o == e.acc, e.tag, "acc", acc_o, e.acc);
        chk(phase_o == e.ph, e.tag, "phase", 32'(phase_o), 32'(e.ph));
        chk(out_en_o == e.en, e.tag, "out_en", 32'(out_en_o), 32'(e.en));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_ni = 0;
    ftw[0] = '0; ftw[1] = '0;
    for (int i = 0; i < 4; i++) phs[i] = '0;
    src_pin = 0; fsel_pin = 0; psel_pin = 0;
    fsel_reg = 0; psel_reg = 0;
    sleep = 0; rst_h = 0; clear = 0;
    // the first rising edge is at 2.5 ns; drive pins so reset must hold
    fsel_pin = 1; psel_pin = 2'd3;
    ftw[0] = 32'h0000_1000;
    #12;
    chk(acc_o == 0, "R10", "acc in reset", acc_o, 0);
    chk(phase_o == 0, "R10", "phase in reset", 32'(phase_o), 0);
    chk(out_en_o == 0, "R10", "out_en in reset", 32'(out_en_o), 0);
    @(negedge clk);
    fsel_pin = 0; psel_pin = 0;
    @(negedge clk);
    rst_ni = 1;

    // R1: accumulation with wrap at 2^32
    ftw[0] = 32'h1000_0000;
    repeat (20) cyc("R1");

    // R2: second tuning word; R5: register selects act at once
    ftw[1] = 32'h0ABC_DEF1;
    fsel_reg = 1;
    repeat (5) cyc("R2");
    for (int i = 0; i < 6; i++) begin
      fsel_reg = i[0];
      cyc("R5");
    end

    // R3: each phase offset, including wrap of the 12-bit sum
    phs[0] = 12'h123; phs[1] = 12'hFFF; phs[2] = 12'h800; phs[3] = 12'h001;
    for (int p = 0; p < 4; p++) begin
      psel_reg = 2'(p);
      cyc("R3");
      cyc("R3");
    end

    // R4: pin selects with two-stage latency
    src_pin = 1; fsel_pin = 1; psel_pin = 2'd2;
    repeat (4) cyc("R4");
    fsel_pin = 0; psel_pin = 2'd3;
    repeat (3) cyc("R4");
    for (int i = 0; i < 6; i++) begin
      fsel_pin = ~fsel_pin;
      psel_pin = 2'(i);
      cyc("R4");
    end

    // R7: sleep freezes
    src_pin = 0; fsel_reg = 1; psel_reg = 2'd1;
    sleep = 1;
    repeat (4) cyc("R7");
    sleep = 0;
    cyc("R7");

    // R8: clear zeroes output, accumulator keeps running
    clear = 1;
    repeat (4) cyc("R8");
    clear = 0;
    cyc("R8");

    // R6: reset beats sleep; R9: enable only with all controls low
    rst_h = 1; sleep = 1;
    repeat (3) cyc("R6");
    rst_h = 0; sleep = 0;
    repeat (2) cyc("R9");
    clear = 1; sleep = 1;
    cyc("R9");
    clear = 0; sleep = 0;
    cyc("R9");
    rst_h = 1;
    repeat (2) cyc("R6");
    rst_h = 0;

    // R1: maximum tuning word wraps every step
    fsel_reg = 0;
    ftw[0] = 32'hFFFF_FFFF;
    repeat (5) cyc("R1");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule